// File: doc/BRIEF.md
# Multi-Core Global Timer with Per-CPU Comparators

This block keeps one 64-bit count that every CPU in a cluster shares. A programmable divider sets how often the count advances. Next to the shared count, each CPU has its own compare bank. A bank holds a 64-bit compare value, a sticky event flag, an optional increment that moves the compare value forward by itself, and one interrupt line.

Software reaches all registers through a single 32-bit register port. The port has a select, a write strobe, a byte address inside a 32-byte window, write data and combinational read data. A CPU-number input picks which compare bank an access uses. The shared count and the shared control fields look the same whatever the CPU number is. The number of CPUs is a parameter.

Top module: `mcore_gtimer`

## Requirements
- R1: After reset, every register reads zero: count words, control, status, compare words and increment, in every bank. Every interrupt output is low.
- R2: While run (control bit 0) is set, the count goes up by exactly one every (D+1) clock cycles, where D is control bits 15:8. The first step comes D+1 cycles after the edge that sets run. While run is clear, the count holds its value.
- R3: While run is clear, a write to offset 0x00 replaces the low 32 bits of the count, and a write to offset 0x04 replaces the high 32 bits.
- R4: While run is set, writes to offsets 0x00 and 0x04 leave the count unchanged.
- R5: Control is at offset 0x08. Run (bit 0) and the divider (bits 15:8) are shared. Compare-enable (bit 1), interrupt-enable (bit 2) and auto-reload (bit 3) are held per CPU. A write updates the shared fields and the accessing CPU's banked bits. A read returns the shared fields ORed with the accessing CPU's banked bits. All other bits read zero.
- R6: When run and a bank's compare-enable are both set, and the count is greater than or equal to that bank's compare value (low word at 0x10, high word at 0x14), the bank's status bit 0 (offset 0x0C) sets on the next edge.
- R7: The status bit is sticky. Writing 1 to bit 0 of 0x0C clears it. Writing 0 leaves it set. A compare hit in the same cycle wins over the clear.
- R8: On a compare hit, if auto-reload is set and the increment (offset 0x18) is nonzero, the compare value advances by the smallest whole multiple of the increment that puts it strictly above the current count.
- R9: Each CPU's interrupt output is high exactly when its status bit and its interrupt-enable bit are both set.
- R10: Offset 0x1C and any address whose two low bits are not zero read as zero, and writes to them change nothing.
- R11: A bank whose compare-enable is clear never sets its status bit, even when the count is above its compare value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address within the 32-byte window |
| bus_wdata | input | 32 | Write data |
| bus_cpu | input | CID_W | Number of the accessing CPU |
| bus_rdata | output | 32 | Read data, combinational from address and CPU number |
| irq_o | output | NUM_CPU | Per-CPU interrupt lines |

## Verification
The assertions assume that the CPU number is always below NUM_CPU. They also assume that a cycle with no write asserted is a true idle cycle, so the count, compare value and status can change only through the timer's own logic. The reload property further assumes that the count moves by at most one per cycle. The bench respects all three assumptions. It drives every access for exactly one cycle and leaves an idle cycle between accesses. It uses only CPU numbers 0 and 1. It runs the reload cases with the largest divider, so the count is still frozen when the moved compare value is read back.

// File: rtl/gt_pkg.sv
package gt_pkg;
   // word index = byte address [4:2]
   localparam logic [2:0] W_CNT_LO = 3'd0;
   localparam logic [2:0] W_CNT_HI = 3'd1;
   localparam logic [2:0] W_CTRL   = 3'd2;
   localparam logic [2:0] W_STAT   = 3'd3;
   localparam logic [2:0] W_CMP_LO = 3'd4;
   localparam logic [2:0] W_CMP_HI = 3'd5;
   localparam logic [2:0] W_INC    = 3'd6;

   localparam int CB_RUN  = 0;
   localparam int CB_CMP  = 1;
   localparam int CB_IRQ  = 2;
   localparam int CB_AUTO = 3;
   localparam int CB_DIV  = 8;

   typedef struct packed {
      logic auto_en;
      logic irq_en;
      logic cmp_en;
   } bank_ctrl_t;
endpackage

// File: rtl/gt_counter.sv
module gt_counter #(
   parameter int CNT_W  = 64,
   parameter int DATA_W = 32,
   parameter int DIV_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [DIV_W-1:0]  div,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [DATA_W-1:0] wdata,
   output logic [CNT_W-1:0]  cnt
);
   logic [DIV_W-1:0] div_q;
   logic             tick;

   assign tick = run && (div_q >= div);

   always_ff @(posedge clk) begin
      if (!rst_n || !run || tick) div_q <= '0;
      else                        div_q <= div_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                cnt <= '0;
      else if (tick)             cnt <= cnt + 1'b1;
      else if (!run && wr_lo)    cnt[DATA_W-1:0] <= wdata;
      else if (!run && wr_hi)    cnt[CNT_W-1:DATA_W] <= wdata;
   end
endmodule

// File: rtl/gt_bank.sv
module gt_bank
   import gt_pkg::*;
#(
   parameter int CNT_W    = 64,
   parameter int DATA_W   = 32,
   parameter bit AUTO_INC = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  cnt,
   input  logic              run,
   input  logic              wr_ctrl,
   input  logic              wr_stat,
   input  logic              wr_cmp_lo,
   input  logic              wr_cmp_hi,
   input  logic              wr_inc,
   input  logic [DATA_W-1:0] wdata,
   output bank_ctrl_t        ctrl_o,
   output logic              status_o,
   output logic [CNT_W-1:0]  cmp_o,
   output logic [DATA_W-1:0] inc_o,
   output logic              irq_o
);
   logic             hit;
   logic             reload_ok;
   logic [CNT_W-1:0] reload_amt;

   assign hit = run && ctrl_o.cmp_en && (cnt >= cmp_o);

   generate
      if (AUTO_INC) begin : g_reload
         logic [CNT_W-1:0] gap, divisor, steps;
         always_comb begin
            gap        = cnt - cmp_o;
            divisor    = (inc_o == '0) ? CNT_W'(1) : CNT_W'(inc_o);
            steps      = gap / divisor + 1'b1;
            reload_amt = steps * CNT_W'(inc_o);
         end
         assign reload_ok = ctrl_o.auto_en && (inc_o != '0);
      end else begin : g_no_reload
         assign reload_amt = '0;
         assign reload_ok  = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)       ctrl_o <= '0;
      else if (wr_ctrl) ctrl_o <= {wdata[CB_AUTO], wdata[CB_IRQ], wdata[CB_CMP]};
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                         status_o <= 1'b0;
      else if (hit)                       status_o <= 1'b1;
      else if (wr_stat && wdata[0])       status_o <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                cmp_o <= '0;
      else if (wr_cmp_lo)        cmp_o[DATA_W-1:0] <= wdata;
      else if (wr_cmp_hi)        cmp_o[CNT_W-1:DATA_W] <= wdata;
      else if (hit && reload_ok) cmp_o <= cmp_o + reload_amt;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      inc_o <= '0;
      else if (wr_inc) inc_o <= wdata;
   end

   assign irq_o = status_o && ctrl_o.irq_en;
endmodule

// File: rtl/mcore_gtimer.sv
module mcore_gtimer
   import gt_pkg::*;
#(
   parameter int NUM_CPU  = 2,
   parameter int DATA_W   = 32,
   parameter int DIV_W    = 8,
   parameter bit AUTO_INC = 1'b1,
   localparam int CNT_W   = 2 * DATA_W,
   localparam int ADDR_W  = 5,
   localparam int CID_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic [CID_W-1:0]  bus_cpu,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [NUM_CPU-1:0] irq_o
);
   initial begin : elab_checks
      if (NUM_CPU < 1) $error("NUM_CPU must be at least 1");
      if (DATA_W != 32) $error("DATA_W must be 32");
      if (DIV_W < 1 || DIV_W > DATA_W - CB_DIV) $error("DIV_W out of range");
   end

   logic [2:0]       widx;
   logic             hit_ok, cpu_ok, wr_ok;
   logic             timer_en_q;
   logic [DIV_W-1:0] div_q;
   logic [CNT_W-1:0] cnt_q;

   logic [NUM_CPU-1:0][CNT_W-1:0]  cmp_all;
   logic [NUM_CPU-1:0][DATA_W-1:0] inc_all;
   logic [NUM_CPU-1:0]             status_all;
   bank_ctrl_t [NUM_CPU-1:0]       ctrl_all;
   logic [NUM_CPU-1:0]             cmp_en_all, auto_en_all;

   assign widx   = bus_addr[4:2];
   assign cpu_ok = (32'(bus_cpu) < NUM_CPU);
   assign hit_ok = bus_sel && (bus_addr[1:0] == 2'b00) && (widx <= W_INC) && cpu_ok;
   assign wr_ok  = hit_ok && bus_wr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         timer_en_q <= 1'b0;
         div_q      <= '0;
      end else if (wr_ok && widx == W_CTRL) begin
         timer_en_q <= bus_wdata[CB_RUN];
         div_q      <= bus_wdata[CB_DIV +: DIV_W];
      end
   end

   gt_counter #(.CNT_W(CNT_W), .DATA_W(DATA_W), .DIV_W(DIV_W)) u_counter (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (timer_en_q),
      .div   (div_q),
      .wr_lo (wr_ok && widx == W_CNT_LO),
      .wr_hi (wr_ok && widx == W_CNT_HI),
      .wdata (bus_wdata),
      .cnt   (cnt_q)
   );

   generate
      for (genvar i = 0; i < NUM_CPU; i++) begin : g_bank
         logic mine;
         assign mine = wr_ok && (32'(bus_cpu) == i);
         gt_bank #(.CNT_W(CNT_W), .DATA_W(DATA_W), .AUTO_INC(AUTO_INC)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .cnt       (cnt_q),
            .run       (timer_en_q),
            .wr_ctrl   (mine && widx == W_CTRL),
            .wr_stat   (mine && widx == W_STAT),
            .wr_cmp_lo (mine && widx == W_CMP_LO),
            .wr_cmp_hi (mine && widx == W_CMP_HI),
            .wr_inc    (mine && widx == W_INC),
            .wdata     (bus_wdata),
            .ctrl_o    (ctrl_all[i]),
            .status_o  (status_all[i]),
            .cmp_o     (cmp_all[i]),
            .inc_o     (inc_all[i]),
            .irq_o     (irq_o[i])
         );
         assign cmp_en_all[i]  = ctrl_all[i].cmp_en;
         assign auto_en_all[i] = ctrl_all[i].auto_en;
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      if (hit_ok && !bus_wr) begin
         case (widx)
            W_CNT_LO: bus_rdata = cnt_q[DATA_W-1:0];
            W_CNT_HI: bus_rdata = cnt_q[CNT_W-1:DATA_W];
            W_CTRL: begin
               bus_rdata[CB_RUN]           = timer_en_q;
               bus_rdata[CB_DIV +: DIV_W]  = div_q;
               bus_rdata[CB_CMP]           = ctrl_all[bus_cpu].cmp_en;
               bus_rdata[CB_IRQ]           = ctrl_all[bus_cpu].irq_en;
               bus_rdata[CB_AUTO]          = ctrl_all[bus_cpu].auto_en;
            end
            W_STAT:   bus_rdata[0] = status_all[bus_cpu];
            W_CMP_LO: bus_rdata = cmp_all[bus_cpu][DATA_W-1:0];
            W_CMP_HI: bus_rdata = cmp_all[bus_cpu][CNT_W-1:DATA_W];
            W_INC:    bus_rdata = inc_all[bus_cpu];
            default:  bus_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/gt_checker.sv
module gt_checker #(
   parameter int NUM_CPU = 2,
   parameter int CNT_W   = 64,
   parameter int DATA_W  = 32
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic                           wr_any,
   input logic                           timer_en,
   input logic [CNT_W-1:0]               cnt,
   input logic [NUM_CPU-1:0][CNT_W-1:0]  cmp,
   input logic [NUM_CPU-1:0][DATA_W-1:0] inc,
   input logic [NUM_CPU-1:0]             cmp_en,
   input logic [NUM_CPU-1:0]             auto_en,
   input logic [NUM_CPU-1:0]             status,
   input logic [NUM_CPU-1:0]             irq
);
   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!timer_en && !wr_any) |=> $stable(cnt));

   p_run_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      timer_en |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));

   generate
      for (genvar i = 0; i < NUM_CPU; i++) begin : g_cpu
         p_hit_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (timer_en && cmp_en[i] && cnt >= cmp[i]) |=> status[i]);

         p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (status[i] && !wr_any) |=> status[i]);

         p_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (timer_en && cmp_en[i] && auto_en[i] && inc[i] != '0
             && cnt >= cmp[i] && !wr_any) |=> (cmp[i] > $past(cnt)));

         p_irq_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
            irq[i] |-> status[i]);

         p_no_hit_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (!cmp_en[i] && !status[i]) |=> !status[i]);
      end
   endgenerate
endmodule

bind mcore_gtimer gt_checker #(.NUM_CPU(NUM_CPU), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_any   (bus_sel & bus_wr),
   .timer_en (timer_en_q),
   .cnt      (cnt_q),
   .cmp      (cmp_all),
   .inc      (inc_all),
   .cmp_en   (cmp_en_all),
   .auto_en  (auto_en_all),
   .status   (status_all),
   .irq      (irq_o)
);

// File: tb/mcore_gtimer_bench.sv
module mcore_gtimer_bench;
   localparam int NCPU = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [0:0]  bus_cpu = '0;
   logic [31:0] bus_rdata;
   logic [NCPU-1:0] irq_o;

   int checks = 0, fails = 0;
   bit done = 1'b0;

   typedef struct {
      bit          is_irq;
      int          idx;
      logic [31:0] exp;
      string       tag;
   } item_t;
   item_t q[$];
   bit mon_go = 1'b0;

   always #5 clk = ~clk;

   mcore_gtimer #(.NUM_CPU(NCPU)) u_mcore_gtimer (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_cpu(bus_cpu),
      .bus_rdata(bus_rdata), .irq_o(irq_o)
   );

   // monitor: pops one expected item per request, compares at negedge
   always @(negedge clk) begin
      if (mon_go) begin
         item_t it;
         logic [31:0] act;
         it = q.pop_front();
         act = it.is_irq ? {31'b0, irq_o[it.idx]} : bus_rdata;
         checks++;
         if (act !== it.exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
         end
         mon_go = 1'b0;
      end
   end

   task automatic wr(input logic [4:0] a, input int cpu, input logic [31:0] d);
      @(posedge clk); #1;
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_cpu = cpu[0]; bus_wdata = d;
      @(posedge clk); #1;
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, input int cpu, input logic [31:0] e, input string tag);
      item_t it;
      @(posedge clk); #1;
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_cpu = cpu[0];
      it.is_irq = 1'b0; it.idx = 0; it.exp = e; it.tag = tag;
      q.push_back(it);
      mon_go = 1'b1;
      @(posedge clk); #1;
      bus_sel = 1'b0;
   endtask

   task automatic irq_chk(input int cpu, input bit e, input string tag);
      item_t it;
      @(posedge clk); #1;
      it.is_irq = 1'b1; it.idx = cpu; it.exp = {31'b0, e}; it.tag = tag;
      q.push_back(it);
      mon_go = 1'b1;
      @(posedge clk); #1;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin : stim
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      rd(5'h00, 0, 32'h0, "R1 cnt lo");
      rd(5'h04, 0, 32'h0, "R1 cnt hi");
      rd(5'h08, 1, 32'h0, "R1 ctrl");
      rd(5'h0C, 0, 32'h0, "R1 status");
      rd(5'h14, 1, 32'h0, "R1 cmp hi");
      rd(5'h18, 0, 32'h0, "R1 inc");
      irq_chk(0, 1'b0, "R1 irq0");

      // R3 counter words while stopped
      wr(5'h00, 0, 32'h1234_5678);
      wr(5'h04, 1, 32'h0000_0009);
      rd(5'h00, 0, 32'h1234_5678, "R3 cnt lo");
      rd(5'h04, 0, 32'h0000_0009, "R3 cnt hi");

      // R4 writes ignored while running (divider 255 keeps count still)
      wr(5'h08, 0, 32'h0000_FF01);
      wr(5'h00, 0, 32'h0000_AAAA);
      wr(5'h04, 0, 32'h0000_0005);
      wr(5'h08, 0, 32'h0);
      rd(5'h00, 0, 32'h1234_5678, "R4 cnt lo kept");
      rd(5'h04, 0, 32'h0000_0009, "R4 cnt hi kept");

      // R2 prescaled counting: ticks every D+1 cycles after enable edge
      wr(5'h00, 0, 32'h0);
      wr(5'h04, 0, 32'h0);
      wr(5'h08, 0, 32'h0000_0301);      // D=3
      repeat (18) @(posedge clk);       // disable edge lands 20 cycles after enable
      wr(5'h08, 0, 32'h0);
      rd(5'h00, 0, 32'd5, "R2 D=3 count");
      wr(5'h08, 0, 32'h0000_0001);      // D=0
      repeat (8) @(posedge clk);
      wr(5'h08, 0, 32'h0);
      rd(5'h00, 0, 32'd15, "R2 D=0 count");
      repeat (10) @(posedge clk);
      rd(5'h00, 0, 32'd15, "R2 hold while stopped");

      // R5 shared vs banked control
      wr(5'h08, 1, 32'hFFFF_FF0E);
      rd(5'h08, 1, 32'h0000_FF0E, "R5 ctrl cpu1");
      rd(5'h08, 0, 32'h0000_FF00, "R5 ctrl cpu0 shared only");
      wr(5'h08, 0, 32'h0000_0004);
      rd(5'h08, 1, 32'h0000_000E, "R5 cpu1 banked kept");
      rd(5'h08, 0, 32'h0000_0004, "R5 cpu0 banked");

      // R6 / R9 / R11 compare hit
      wr(5'h08, 1, 32'h0);              // cpu1 compare off
      wr(5'h10, 0, 32'd40);
      wr(5'h08, 0, 32'h0000_0007);      // run, cmp, irq for cpu0
      rd(5'h0C, 0, 32'h0, "R6 no hit before reach");
      irq_chk(0, 1'b0, "R9 irq0 low before hit");
      repeat (40) @(posedge clk);
      rd(5'h0C, 0, 32'h1, "R6 status after reach");
      irq_chk(0, 1'b1, "R9 irq0 high");
      rd(5'h0C, 1, 32'h0, "R11 cpu1 disabled no hit");
      irq_chk(1, 1'b0, "R11 irq1 low");

      // R7 sticky status, R9 enable gating
      wr(5'h0C, 0, 32'hFFFF_FFFE);
      rd(5'h0C, 0, 32'h1, "R7 write 0 keeps status");
      wr(5'h08, 0, 32'h0000_0003);
      irq_chk(0, 1'b0, "R9 irq gated by enable");
      wr(5'h08, 0, 32'h0000_0005);      // compare off, irq on
      irq_chk(0, 1'b1, "R9 irq back on");
      wr(5'h0C, 0, 32'h0000_0001);
      rd(5'h0C, 0, 32'h0, "R7 write 1 clears");
      irq_chk(0, 1'b0, "R7 irq low after clear");

      // R8 auto reload: cnt 100, cmp 10, inc 7 -> 101
      wr(5'h08, 0, 32'h0);
      wr(5'h00, 0, 32'd100);
      wr(5'h04, 0, 32'h0);
      wr(5'h10, 1, 32'd10);
      wr(5'h18, 1, 32'd7);
      wr(5'h08, 1, 32'h0000_FF0F);
      wr(5'h08, 1, 32'h0000_000E);
      rd(5'h10, 1, 32'd101, "R8 reload to multiple past count");
      rd(5'h0C, 1, 32'h1, "R8 status set");
      rd(5'h00, 0, 32'd100, "R8 count unchanged");
      irq_chk(1, 1'b1, "R9 irq1 high");
      // exact multiple: cmp 93 -> gap 7 -> must land at 107, not 100
      wr(5'h0C, 1, 32'h1);
      wr(5'h10, 1, 32'd93);
      wr(5'h08, 1, 32'h0000_FF0F);
      wr(5'h08, 1, 32'h0000_000E);
      rd(5'h10, 1, 32'd107, "R8 strictly above count");
      // zero increment: no reload
      wr(5'h0C, 1, 32'h1);
      wr(5'h18, 1, 32'h0);
      wr(5'h10, 1, 32'd50);
      wr(5'h08, 1, 32'h0000_FF0F);
      wr(5'h08, 1, 32'h0000_000E);
      rd(5'h10, 1, 32'd50, "R8 zero inc keeps compare");
      rd(5'h0C, 1, 32'h1, "R8 zero inc status");

      // R10 unmapped and misaligned
      wr(5'h1C, 0, 32'hFFFF_FFFF);
      rd(5'h1C, 0, 32'h0, "R10 offset 0x1C reads 0");
      rd(5'h0B, 1, 32'h0, "R10 misaligned read 0");
      wr(5'h0A, 0, 32'h0000_FF0F);
      rd(5'h08, 0, 32'h0, "R10 misaligned write ignored");

      repeat (3) @(posedge clk);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule